// File: doc/BRIEF.md
# Dual 8-bit GPIO port controller

This block runs two independent 8-bit general-purpose I/O ports, called G and H, behind a small register interface. Each port has an output latch, a read-only view of its pin levels and a direction register. Each pin's output enable comes from its direction bit, and its driven value comes from its latch bit. The pad inputs pass through a two-flop synchronizer before software can read them.

The registers of the two ports share 16-bit words. Port G is the upper byte and port H is the lower byte. Two byte strobes choose which half a write changes, so the bus can reach one port alone or both ports in a single word access.

There are two reset inputs, and they act differently. Power-on reset clears everything. System reset clears the directions, the synchronizers and the read path, but it leaves the output latches as they were. While system reset is low, writes are ignored.

Top module: `gpio_pair_ctl`

## Requirements
- R1: Either reset (`por_n` or `sys_rst_n` low) clears every direction bit. All output enables are then 0, and the direction word reads 0x0000.
- R2: `g_oe`/`h_oe` equal the port's direction bits (1 = output, 0 = input). `g_out`/`h_out` equal the port's latch bits.
- R3: Only power-on reset clears the output latches to 0. A system reset leaves `g_out`, `h_out` and the output-latch word unchanged.
- R4: Reading the output-latch word returns the latch contents, not the pin levels.
- R5: Reading the pin word returns the synchronized level of every pin, whether that pin is an input or an output.
- R6: Writes to the pin word change no register and no output.
- R7: The address map uses the word index `addr[5:1]`, and `addr[0]` is ignored. Offset 0x28 is the output-latch word, 0x2A is the pin word and 0x2C is the direction word. Bits 15:8 hold port G and bits 7:0 hold port H. Every other offset reads 0x0000.
- R8: On a write, `be[1]` enables the update of port G (bits 15:8) and `be[0]` enables the update of port H (bits 7:0). A lane whose strobe is 0 keeps its value.
- R9: A change on a pad input first shows in read data sampled at the third rising clock edge after the change.
- R10: A read (`sel`=1, `wr`=0) sampled at a rising edge gives `rvalid`=1 and the read word on `rdata` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| sel | input | 1 | Bus access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte offset of the access |
| be | input | 2 | Byte lane strobes: [1] = port G, [0] = port H |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid |
| g_pad_in | input | 8 | Port G pad levels |
| h_pad_in | input | 8 | Port H pad levels |
| g_out | output | 8 | Port G driven values |
| g_oe | output | 8 | Port G output enables |
| h_out | output | 8 | Port H driven values |
| h_oe | output | 8 | Port H output enables |

## Verification
The pin word is read in several configurations, each chosen to separate two sources of data:
- All pins are inputs, with external levels that differ from the latches. This separates the pin word from the output-latch word.
- Port G is set to output with a loop-back pad model. This shows that the pin word follows the driven value rather than the external level.
- A pad changes while reads are issued on three consecutive cycles. This pins the synchronizer latency to exactly two flops.

Single-lane writes, with each strobe alone, show which half of the word each strobe reaches. A write to the pin word, a system reset and a power-on reset show which state each of them leaves untouched.

// File: rtl/gpio_pair_ctl.sv
module gpio_pair_ctl #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] BASE_OFS = 6'h28
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  sys_rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            be,
  input  logic [2*PORT_W-1:0]   wdata,
  output logic [2*PORT_W-1:0]   rdata,
  output logic                  rvalid,
  input  logic [PORT_W-1:0]     g_pad_in,
  input  logic [PORT_W-1:0]     h_pad_in,
  output logic [PORT_W-1:0]     g_out,
  output logic [PORT_W-1:0]     g_oe,
  output logic [PORT_W-1:0]     h_out,
  output logic [PORT_W-1:0]     h_oe
);
  localparam int BUS_W = 2*PORT_W;
  localparam logic [ADDR_W-2:0] OUT_IDX = BASE_OFS[ADDR_W-1:1];
  localparam logic [ADDR_W-2:0] PIN_IDX = OUT_IDX + 1'b1;
  localparam logic [ADDR_W-2:0] DIR_IDX = OUT_IDX + 2'd2;

  logic rst_any_n;
  logic [ADDR_W-2:0] widx;
  logic wr_ok, wr_out, wr_dir;
  logic [PORT_W-1:0] g_lat, h_lat, g_dir, h_dir;
  logic [PORT_W-1:0] g_s1, g_s2, h_s1, h_s2;
  logic [BUS_W-1:0] rd_word;
  wire unused_lsb = addr[0];

  assign rst_any_n = por_n & sys_rst_n;
  assign widx   = addr[ADDR_W-1:1];
  assign wr_ok  = sel & wr & sys_rst_n;
  assign wr_out = wr_ok && (widx == OUT_IDX);
  assign wr_dir = wr_ok && (widx == DIR_IDX);

  assign g_out = g_lat;
  assign h_out = h_lat;
  assign g_oe  = g_dir;
  assign h_oe  = h_dir;

  // Output latches: only power-on reset touches them
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      g_lat <= '0;
      h_lat <= '0;
    end else if (wr_out) begin
      if (be[1]) g_lat <= wdata[BUS_W-1:PORT_W];
      if (be[0]) h_lat <= wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      g_dir <= '0;
      h_dir <= '0;
    end else if (wr_dir) begin
      if (be[1]) g_dir <= wdata[BUS_W-1:PORT_W];
      if (be[0]) h_dir <= wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      g_s1 <= '0; g_s2 <= '0;
      h_s1 <= '0; h_s2 <= '0;
    end else begin
      g_s1 <= g_pad_in; g_s2 <= g_s1;
      h_s1 <= h_pad_in; h_s2 <= h_s1;
    end
  end

  always_comb begin
    unique case (widx)
      OUT_IDX: rd_word = {g_lat, h_lat};
      PIN_IDX: rd_word = {g_s2, h_s2};
      DIR_IDX: rd_word = {g_dir, h_dir};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= sel & ~wr;
      if (sel && !wr) rdata <= rd_word;
    end
  end

  // R1
  dir_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> (g_oe == '0 && h_oe == '0));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> ($stable(g_out) && $stable(h_out)));

  // R6
  pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
    (sel && wr && widx == PIN_IDX) |=>
      ($stable(g_out) && $stable(h_out) && $stable(g_oe) && $stable(h_oe)));

  // R8
  lane_g_keep_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
    (sel && wr && !be[1]) |=> ($stable(g_out) && $stable(g_oe)));

  // R8
  lane_h_keep_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
    (sel && wr && !be[0]) |=> ($stable(h_out) && $stable(h_oe)));

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
    (sel && !wr) |=> rvalid);
endmodule

// File: tb/gpio_pair_ctl_tb.sv
module gpio_pair_ctl_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid;
  logic [7:0] g_out, g_oe, h_out, h_oe;
  logic [7:0] ext_g = '0, ext_h = '0;
  logic [7:0] g_pad, h_pad;

  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  assign g_pad = (g_oe & g_out) | (~g_oe & ext_g);
  assign h_pad = (h_oe & h_out) | (~h_oe & ext_h);

  always #5 clk = ~clk;

  gpio_pair_ctl u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .sel(sel), .wr(wr), .addr(addr), .be(be), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid),
    .g_pad_in(g_pad), .h_pad_in(h_pad),
    .g_out(g_out), .g_oe(g_oe), .h_out(h_out), .h_oe(h_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
    end
  endtask

  task automatic wr_bus(input logic [5:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; be = b; wdata = d;
  endtask

  task automatic rd_bus(input logic [5:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a; be = 2'b11;
    exp_q.push_back(exp);
    tag_q.push_back(req);
  endtask

  // monitor: registered read data is stable at the falling edge
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {16'h0, rdata}, {16'h0, e});
      end
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    por_n = 1'b1; sys_rst_n = 1'b1;
    idle(1);
    check("R1 g_oe after reset", {24'h0, g_oe}, 32'h0);
    check("R1 h_oe after reset", {24'h0, h_oe}, 32'h0);
    check("R3 por clears g_out", {24'h0, g_out}, 32'h0);
    check("R10 rvalid idle", {31'h0, rvalid}, 32'h0);
    rd_bus(6'h2C, 16'h0000, "R1 dir word");
    rd_bus(6'h28, 16'h0000, "R7 out word after por");

    wr_bus(6'h28, 2'b11, 16'hA55A);
    rd_bus(6'h28, 16'hA55A, "R7 out word");
    idle(1);
    check("R2 g_out latch", {24'h0, g_out}, 32'hA5);
    check("R2 h_out latch", {24'h0, h_out}, 32'h5A);
    check("R2 g_oe still input", {24'h0, g_oe}, 32'h0);

    ext_g = 8'h0F; ext_h = 8'hF0;
    idle(3);
    rd_bus(6'h2A, 16'h0FF0, "R5 pin word inputs");
    rd_bus(6'h28, 16'hA55A, "R4 out word not pins");

    wr_bus(6'h2C, 2'b11, 16'hFF00);
    idle(1);
    check("R2 g_oe from dir", {24'h0, g_oe}, 32'hFF);
    check("R2 h_oe from dir", {24'h0, h_oe}, 32'h00);
    idle(3);
    rd_bus(6'h2A, 16'hA5F0, "R5 pin word driven outputs");

    wr_bus(6'h29, 2'b01, 16'h77C3);
    rd_bus(6'h28, 16'hA5C3, "R8 be[0] only port H");
    wr_bus(6'h28, 2'b10, 16'h1299);
    rd_bus(6'h28, 16'h12C3, "R8 be[1] only port G");

    wr_bus(6'h2A, 2'b11, 16'hFFFF);
    rd_bus(6'h28, 16'h12C3, "R6 out word after pin write");
    rd_bus(6'h2C, 16'hFF00, "R6 dir word after pin write");
    rd_bus(6'h30, 16'h0000, "R7 unmapped offset");
    idle(4);

    // R9: change pad and read on three back-to-back cycles
    @(negedge clk);
    ext_h = 8'h55;
    sel = 1'b1; wr = 1'b0; addr = 6'h2A; be = 2'b11;
    exp_q.push_back(16'h12F0); tag_q.push_back("R9 first edge old");
    rd_bus(6'h2A, 16'h12F0, "R9 second edge old");
    rd_bus(6'h2A, 16'h1255, "R9 third edge new");
    idle(3);

    @(negedge clk);
    sys_rst_n = 1'b0;
    idle(2);
    check("R1 g_oe in sys reset", {24'h0, g_oe}, 32'h0);
    check("R3 g_out kept", {24'h0, g_out}, 32'h12);
    check("R3 h_out kept", {24'h0, h_out}, 32'hC3);
    sys_rst_n = 1'b1;
    rd_bus(6'h2C, 16'h0000, "R1 dir word after sys reset");
    rd_bus(6'h28, 16'h12C3, "R3 out word after sys reset");
    idle(3);

    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(1);
    check("R3 por clears g_out", {24'h0, g_out}, 32'h0);
    rd_bus(6'h28, 16'h0000, "R3 out word after por");
    idle(3);
    check("R10 all reads answered", exp_q.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule